// File: doc/BRIEF.md
# Multichannel ADC Acquisition and Overlimit Alarm Controller

This block sits on the host side of an external 8-bit converter that samples all of its channels at the same instant. It runs without being started. After a quiet interval it gives the converter a write strobe to start a conversion. It then waits for the converter's busy line to go low and come back high. After that it reads the results with a burst of read strobes, one per channel, lowest channel first. Each value is presented on a result port with a channel number and a one-cycle valid strobe.

Each value read is compared with a per-channel limit. Each channel has a small saturating counter of consecutive over-limit readings. When any channel reads above its limit on three acquisitions in a row, an alarm output and a transmitter-protection output are raised. Both stay latched until the host pulses a clear input. If the converter never finishes a conversion, the sequence gives up after a bounded wait, raises a sticky timeout flag and starts over.

Top module: `adc_alarm_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `wr_n` and `rd_n` are 1, and `res_valid`, `alarm`, `protect` and `tmo_err` are 0.
- R2: Each acquisition begins with `wr_n` low for exactly `WR_W` cycles. Before every falling edge of `wr_n`, both strobes have been high for at least `GAP` consecutive cycles, counted from reset or from the previous acquisition.
- R3: After `busy_n` has been seen low and then high again, `NCH` read pulses follow. Each holds `rd_n` low for `RD_W` cycles, with `RD_W` high cycles after each one. `adc_d` is captured `RD_SAMP` cycles after `rd_n` falls. Its value appears on `res_data` with `res_valid` high for one cycle, and `res_ch` counts 0, 1, …, `NCH-1` within the acquisition.
- R4: A reading is over its limit only when it is strictly greater than the limit for its channel. The limit is the unsigned field `lim_vec[ch*8 +: 8]`. A reading equal to the limit never counts.
- R5: When a channel's third over-limit reading in a row is captured, `alarm` and `protect` go high in the same cycle as that reading's `res_valid`.
- R6: A reading at or below the limit resets that channel's run of over-limit readings. Two over-limit readings, one normal reading and two more over-limit readings do not raise the alarm.
- R7: `alarm` and `protect` stay high through later normal readings until `alarm_clr` is high for a cycle. The clear also zeroes every channel's run counter and `tmo_err`. If a trip lands in the same cycle as a clear, the trip wins.
- R8: If `busy_n` has not gone low and then high within `TMO` cycles after `wr_n` rises, `tmo_err` is set, no read pulse is issued, and a new acquisition follows after the gap.
- R9: `wr_n` and `rd_n` are never low in the same cycle.
- R10: Runs are kept per channel. Over-limit readings that fall on different channels in successive acquisitions never add up to an alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_n | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_d | input | 8 | Converter data bus |
| lim_vec | input | NCH*8 | Per-channel limits, channel i in bits [i*8 +: 8] |
| alarm_clr | input | 1 | Clears alarm, protect, timeout flag and run counters |
| wr_n | output | 1 | Conversion start strobe, active low |
| rd_n | output | 1 | Result read strobe, active low |
| res_data | output | 8 | Captured channel result |
| res_ch | output | $clog2(NCH) | Channel number of `res_data` |
| res_valid | output | 1 | One-cycle strobe for `res_data`/`res_ch` |
| alarm | output | 1 | Latched overlimit alarm |
| protect | output | 1 | Latched transmitter protection shutdown |
| tmo_err | output | 1 | Sticky conversion timeout flag |

## Verification
The hardest state to reach is the one in which a channel's run counter sits at two, together with another channel's counter being non-zero. Only a chain of complete acquisitions with chosen per-channel values gets the block there. The bench models the converter. It latches a per-channel value array on the falling edge of the write strobe and serves those values through a pointer that advances on each read strobe. Each acquisition's array is chosen so that runs are built, broken, interleaved across channels and swept over every channel. A stall switch in the model keeps busy high and so drives the timeout path.

// File: rtl/adc_alarm_pkg.sv
package adc_alarm_pkg;
  typedef enum logic [2:0] {
    ST_GAP,
    ST_WR,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_RD_LO,
    ST_RD_HI
  } acq_state_t;
endpackage

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
  import adc_alarm_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int GAP     = 100,
  parameter int WR_W    = 4,
  parameter int RD_W    = 4,
  parameter int RD_SAMP = 2,
  parameter int TMO     = 1000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy_ok,
  output logic                   wr_n,
  output logic                   rd_n,
  output logic                   smp,
  output logic [$clog2(NCH)-1:0] ch,
  output logic                   tmo_hit
);
  localparam int CW    = $clog2(NCH);
  localparam int MA    = (GAP > TMO) ? GAP : TMO;
  localparam int MB    = (WR_W > RD_W) ? WR_W : RD_W;
  localparam int CNT_W = $clog2(((MA > MB) ? MA : MB) + 1);

  acq_state_t       st, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt     = st;
    tmo_hit = 1'b0;
    case (st)
      ST_GAP:     if (cnt == CNT_W'(GAP - 1)) nxt = ST_WR;
      ST_WR:      if (cnt == CNT_W'(WR_W - 1)) nxt = ST_WAIT_LO;
      ST_WAIT_LO: begin
        if (!busy_ok) nxt = ST_WAIT_HI;
        else if (cnt == CNT_W'(TMO - 1)) begin
          nxt     = ST_GAP;
          tmo_hit = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (busy_ok) nxt = ST_RD_LO;
        else if (cnt == CNT_W'(TMO - 1)) begin
          nxt     = ST_GAP;
          tmo_hit = 1'b1;
        end
      end
      ST_RD_LO:   if (cnt == CNT_W'(RD_W - 1)) nxt = ST_RD_HI;
      ST_RD_HI: begin
        if (cnt == CNT_W'(RD_W - 1))
          nxt = (ch == CW'(NCH - 1)) ? ST_GAP : ST_RD_LO;
      end
      default:    nxt = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_GAP;
      cnt  <= '0;
      ch   <= '0;
      wr_n <= 1'b1;
      rd_n <= 1'b1;
    end else begin
      st <= nxt;
      // timeout window spans both wait states
      if (nxt != st && !(st == ST_WAIT_LO && nxt == ST_WAIT_HI)) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (st == ST_WAIT_HI && nxt == ST_RD_LO) ch <= '0;
      else if (st == ST_RD_HI && nxt == ST_RD_LO) ch <= ch + 1'b1;
      wr_n <= (nxt != ST_WR);
      rd_n <= (nxt != ST_RD_LO);
    end
  end

  assign smp = (st == ST_RD_LO) && (cnt == CNT_W'(RD_SAMP));
endmodule

// File: rtl/adc_limit_mon.sv
module adc_limit_mon #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp,
  input  logic [$clog2(NCH)-1:0] ch,
  input  logic [DW-1:0]          data,
  input  logic [NCH*DW-1:0]      lim_vec,
  input  logic                   clr,
  output logic                   alarm,
  output logic                   protect
);
  localparam int CW = $clog2(NCH);

  logic [1:0]    run [NCH];
  logic [DW-1:0] lim_sel;
  logic [1:0]    run_sel;
  logic          over, trip;

  assign lim_sel = lim_vec[ch*DW +: DW];
  assign run_sel = run[ch];
  assign over    = data > lim_sel;
  assign trip    = smp && over && (run_sel >= 2'd2);

  for (genvar i = 0; i < NCH; i++) begin : g_run
    always_ff @(posedge clk) begin
      if (rst) run[i] <= 2'd0;
      else if (smp && ch == CW'(i)) begin
        if (!over) run[i] <= 2'd0;
        else if (run[i] != 2'd3) run[i] <= run[i] + 2'd1;
      end else if (clr) run[i] <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm   <= 1'b0;
      protect <= 1'b0;
    end else if (trip) begin
      alarm   <= 1'b1;
      protect <= 1'b1;
    end else if (clr) begin
      alarm   <= 1'b0;
      protect <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_alarm_ctrl.sv
module adc_alarm_ctrl #(
  parameter int NCH     = 8,
  parameter int DW      = 8,
  parameter int GAP     = 100,
  parameter int WR_W    = 4,
  parameter int RD_W    = 4,
  parameter int RD_SAMP = 2,
  parameter int TMO     = 1000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy_n,
  input  logic [DW-1:0]          adc_d,
  input  logic [NCH*DW-1:0]      lim_vec,
  input  logic                   alarm_clr,
  output logic                   wr_n,
  output logic                   rd_n,
  output logic [DW-1:0]          res_data,
  output logic [$clog2(NCH)-1:0] res_ch,
  output logic                   res_valid,
  output logic                   alarm,
  output logic                   protect,
  output logic                   tmo_err
);
  localparam int CW = $clog2(NCH);

  logic          busy_meta, busy_s;
  logic          smp, tmo_hit;
  logic [CW-1:0] ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_meta <= 1'b1;
      busy_s    <= 1'b1;
    end else begin
      busy_meta <= busy_n;
      busy_s    <= busy_meta;
    end
  end

  adc_acq_seq #(
    .NCH(NCH), .GAP(GAP), .WR_W(WR_W), .RD_W(RD_W),
    .RD_SAMP(RD_SAMP), .TMO(TMO)
  ) u_seq (
    .clk(clk), .rst(rst), .busy_ok(busy_s),
    .wr_n(wr_n), .rd_n(rd_n), .smp(smp), .ch(ch), .tmo_hit(tmo_hit)
  );

  adc_limit_mon #(.NCH(NCH), .DW(DW)) u_mon (
    .clk(clk), .rst(rst), .smp(smp), .ch(ch), .data(adc_d),
    .lim_vec(lim_vec), .clr(alarm_clr), .alarm(alarm), .protect(protect)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_ch    <= '0;
      res_valid <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      res_valid <= smp;
      if (smp) begin
        res_data <= adc_d;
        res_ch   <= ch;
      end
      if (tmo_hit) tmo_err <= 1'b1;
      else if (alarm_clr) tmo_err <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_alarm_chk.sv
module adc_alarm_chk #(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int GAP  = 100,
  parameter int WR_W = 4,
  parameter int RD_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCH*DW-1:0]      lim_vec,
  input logic                   alarm_clr,
  input logic                   wr_n,
  input logic                   rd_n,
  input logic [DW-1:0]          res_data,
  input logic [$clog2(NCH)-1:0] res_ch,
  input logic                   res_valid,
  input logic                   alarm,
  input logic                   protect,
  input logic                   tmo_err
);
  int wr_lo, rd_lo, hi_run;
  logic [$clog2(NCH)-1:0] last_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_lo   <= 0;
      rd_lo   <= 0;
      hi_run  <= 0;
      last_ch <= '0;
    end else begin
      wr_lo  <= wr_n ? 0 : wr_lo + 1;
      rd_lo  <= rd_n ? 0 : rd_lo + 1;
      hi_run <= (wr_n && rd_n) ? ((hi_run < GAP + 1) ? hi_run + 1 : hi_run) : 0;
      if (res_valid) last_ch <= res_ch;
    end
  end

  AST_NO_WR_RD_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && !rd_n)); // R9
  AST_WR_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> wr_lo == WR_W); // R2
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> hi_run >= GAP); // R2
  AST_RD_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> rd_lo == RD_W); // R3
  AST_CH_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ch != '0) |-> res_ch == last_ch + 1'b1); // R3
  AST_TRIP_ON_OVER: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> (res_valid && res_data > lim_vec[res_ch*DW +: DW])); // R5
  AST_ALARM_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (alarm && !alarm_clr) |=> alarm); // R7
  AST_PROTECT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (protect && !alarm_clr) |=> protect); // R7
  AST_TMO_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |-> (wr_n && rd_n)); // R8
endmodule

bind adc_alarm_ctrl adc_alarm_chk #(
  .NCH(NCH), .DW(DW), .GAP(GAP), .WR_W(WR_W), .RD_W(RD_W)
) u_chk (
  .clk(clk), .rst(rst), .lim_vec(lim_vec), .alarm_clr(alarm_clr),
  .wr_n(wr_n), .rd_n(rd_n), .res_data(res_data), .res_ch(res_ch),
  .res_valid(res_valid), .alarm(alarm), .protect(protect), .tmo_err(tmo_err)
);

// File: tb/adc_alarm_ctrl_test.sv
module adc_alarm_ctrl_test;
  localparam int NCH = 8, DW = 8, GAP = 10, WR_W = 2, RD_W = 3;
  localparam int RD_SAMP = 1, TMO = 40, CONV = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, busy_n = 1'b1, alarm_clr = 1'b0, stall = 1'b0;
  logic [DW-1:0] adc_d;
  logic [NCH*DW-1:0] lim_vec;
  logic wr_n, rd_n, res_valid, alarm, protect, tmo_err;
  logic [DW-1:0] res_data;
  logic [2:0] res_ch;

  adc_alarm_ctrl #(.NCH(NCH), .DW(DW), .GAP(GAP), .WR_W(WR_W), .RD_W(RD_W),
    .RD_SAMP(RD_SAMP), .TMO(TMO)) uut (
    .clk(clk), .rst(rst), .busy_n(busy_n), .adc_d(adc_d), .lim_vec(lim_vec),
    .alarm_clr(alarm_clr), .wr_n(wr_n), .rd_n(rd_n), .res_data(res_data),
    .res_ch(res_ch), .res_valid(res_valid), .alarm(alarm), .protect(protect),
    .tmo_err(tmo_err));

  int total = 0, bad = 0;
  int lim [NCH];
  logic [7:0] chval [NCH];
  logic [7:0] lat [NCH];
  int ptr = 0, cc = 0;
  logic wr_q = 1'b1, rd_q = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic set_lims();
    for (int i = 0; i < NCH; i++) lim_vec[i*DW +: DW] = 8'(lim[i]);
  endtask

  // converter model: latch on write fall, busy after write rise, pointer per read
  assign adc_d = lat[ptr[2:0]];
  always @(posedge clk) begin
    wr_q <= wr_n;
    rd_q <= rd_n;
    if (wr_q && !wr_n) begin
      for (int i = 0; i < NCH; i++) lat[i] <= chval[i];
      ptr <= 0;
    end else if (!rd_q && rd_n) ptr <= ptr + 1;
    if (!wr_q && wr_n && !stall) begin
      busy_n <= 1'b0;
      cc <= CONV;
    end else if (!busy_n) begin
      if (cc == 1) busy_n <= 1'b1;
      cc <= cc - 1;
    end
  end

  // monitor and reference model
  int exp_idx = 0, acq_done = 0, vcount = 0, wlo = 0, rlo = 0, hic = 0;
  int mc [NCH];
  bit aexp = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (res_valid) begin
      vcount++;
      chk(res_ch == 3'(exp_idx), "R3 channel order", res_ch, exp_idx);
      chk(res_data == lat[res_ch], "R3 result data", res_data, lat[res_ch]);
      if (int'(res_data) > lim[res_ch]) begin
        if (mc[res_ch] < 3) mc[res_ch]++;
      end else mc[res_ch] = 0;
      if (mc[res_ch] == 3) aexp = 1'b1;
      chk(alarm == aexp, "R5 alarm", alarm, aexp);
      chk(protect == aexp, "R5 protect", protect, aexp);
      exp_idx = (exp_idx + 1) % NCH;
      if (exp_idx == 0) acq_done++;
    end
    if (!wr_n) begin
      if (wlo == 0) begin
        chk(hic >= GAP, "R2 gap before write", hic, GAP);
        chk(rd_n == 1'b1, "R9 strobes exclusive", rd_n, 1);
      end
      wlo++;
    end else if (wlo > 0) begin
      chk(wlo == WR_W, "R2 write width", wlo, WR_W);
      wlo = 0;
    end
    if (!rd_n) begin
      if (rlo == 0) chk(wr_n == 1'b1, "R9 strobes exclusive", wr_n, 1);
      rlo++;
    end else if (rlo > 0) begin
      chk(rlo == RD_W, "R3 read width", rlo, RD_W);
      rlo = 0;
    end
    if (wr_n && rd_n) hic++; else hic = 0;
  end

  task automatic wait_acq(input int n);
    int t;
    t = acq_done;
    while (acq_done < t + n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(posedge clk); #2;
    alarm_clr = 1'b1;
    for (int i = 0; i < NCH; i++) mc[i] = 0;
    aexp = 1'b0;
    @(posedge clk); #2;
    alarm_clr = 1'b0;
    @(negedge clk);
    chk(alarm == 1'b0 && protect == 1'b0, "R7 clear", alarm, 0);
    chk(tmo_err == 1'b0, "R7 clear timeout flag", tmo_err, 0);
  endtask

  task automatic all_below(input int k);
    for (int i = 0; i < NCH; i++) chval[i] = 8'(lim[i] - ((i * 3 + k) % 9));
  endtask

  task automatic one_over(input int c, input int k);
    all_below(k);
    chval[c] = 8'(lim[c] + 1 + ((c + k) * 7) % 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      lim[i] = 60 + i * 20;
      mc[i] = 0;
      lat[i] = 8'd0;
    end
    set_lims();
    all_below(0);
    repeat (3) @(posedge clk);
    #2;
    chk(wr_n && rd_n && !res_valid, "R1 strobes in reset", {wr_n, rd_n, res_valid}, 6);
    chk(!alarm && !protect && !tmo_err, "R1 flags in reset", {alarm, protect, tmo_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_n && rd_n && !res_valid, "R1 idle after reset", {wr_n, rd_n, res_valid}, 6);
    chk(!alarm && !protect && !tmo_err, "R1 flags after reset", {alarm, protect, tmo_err}, 0);

    // R4: readings at or below the limit, including equality
    for (int k = 1; k <= 3; k++) begin wait_acq(1); all_below(k); end
    wait_acq(1);
    for (int i = 0; i < NCH; i++) chval[i] = 8'(lim[i]);
    wait_acq(3);
    chk(alarm == 1'b0, "R4 equal never counts", alarm, 0);

    // R6: broken run on channel 3
    one_over(3, 0); wait_acq(2);
    all_below(5);   wait_acq(1);
    one_over(3, 1); wait_acq(2);
    chk(alarm == 1'b0, "R6 run reset by normal reading", alarm, 0);
    pulse_clr();

    // R10: over-limit rotating across channels
    for (int c = 0; c < NCH; c++) begin one_over(c, c); wait_acq(1); end
    chk(alarm == 1'b0, "R10 runs per channel", alarm, 0);

    // R5/R7: trip sweep over every channel
    for (int c = 0; c < NCH; c++) begin
      pulse_clr();
      one_over(c, 0); wait_acq(2);
      chk(alarm == 1'b0, "R5 no trip after two", alarm, 0);
      one_over(c, 2); wait_acq(1);
      chk(alarm == 1'b1 && protect == 1'b1, "R5 trip after three", alarm, 1);
      all_below(c);   wait_acq(1);
      chk(alarm == 1'b1 && protect == 1'b1, "R7 latched", protect, 1);
    end
    pulse_clr();

    // R4 limit extremes
    lim[0] = 255; lim[1] = 0; set_lims();
    all_below(0); chval[0] = 8'd255; chval[1] = 8'd0;
    wait_acq(3);
    chk(alarm == 1'b0, "R4 extremes at limit", alarm, 0);
    chval[1] = 8'd1;
    wait_acq(3);
    chk(alarm == 1'b1, "R4 one above zero limit", alarm, 1);
    lim[0] = 60; lim[1] = 80; set_lims();
    all_below(1);
    wait_acq(1);
    pulse_clr();

    // R8: converter never responds
    begin
      int v0, n;
      v0 = vcount;
      stall = 1'b1;
      n = 0;
      while (!tmo_err && n < 500) begin @(negedge clk); n++; end
      chk(tmo_err == 1'b1, "R8 timeout flag", tmo_err, 1);
      chk(vcount == v0, "R8 no reads on timeout", vcount, v0);
      stall = 1'b0;
    end
    wait_acq(2);
    chk(tmo_err == 1'b1, "R8 timeout sticky", tmo_err, 1);
    pulse_clr();
    wait_acq(1);
    summary();
  end
endmodule